// File: doc/BRIEF.md
# Dual-Direction Serial Byte Queue with Interrupt Thresholds

This block sits between a serial port's shift logic and the CPU. It holds two independent byte queues. The receive queue takes bytes from the deserializer and hands them to a CPU read port. The transmit queue takes CPU writes and hands bytes to the serializer. Each queue has its own controls:

- an enable that picks between a deep queue and a single-byte buffer;
- a flush strobe;
- a fill-level output;
- an interrupt threshold;
- a transparent mode that changes when the interrupt is raised.

The receive side also signals an overrun when a byte arrives and there is no room for it. Both read ports are show-ahead: the oldest byte is always visible. A read or take strobe removes that byte at the next clock edge.

The threshold is a code `c` in the range 0..DEPTH-1 and selects a level of `c+1`. In normal mode, the receive interrupt fires when the held count climbs to that level. The transmit interrupt fires when the number of free slots climbs to that level. In transparent mode, the receive interrupt follows "queue not empty". The transmit interrupt pulses after every stored write that leaves at least one slot free.

Top module: `sio_fifo_pair`

## Requirements
- R1: After reset, rx_level and tx_level are 0, and rx_irq, tx_irq, rx_overrun and tx_out_valid are all 0.
- R2: With the enable set, a queue holds up to DEPTH (8) bytes and delivers them in arrival order. Its level output reports the count held, updated at the edge that stores or removes a byte.
- R3: With the enable clear, a queue holds at most one byte, and further stores are refused until that byte is removed.
- R4: A flush strobe makes the level 0 at the next edge and discards a byte offered in the same cycle; bytes stored earlier are never delivered.
- R5: A receive byte offered when the queue has no room (and no read in that cycle) is discarded, the level is unchanged, and rx_overrun is 1 for exactly the cycle after that edge.
- R6: A transmit write offered when the queue has no room is ignored: tx_level and tx_out_data are unchanged.
- R7: In receive normal mode, rx_irq is 1 for one cycle, starting at the edge where rx_level rises from below (rx_trig+1) to at least (rx_trig+1); a rise that stays below that level does not set it.
- R8: While rx_transparent is held, rx_irq equals (rx_level != 0) in every cycle.
- R9: In transmit normal mode, tx_irq is 1 for one cycle, starting at the edge where the free slot count (capacity minus tx_level) rises from below (tx_trig+1) to at least (tx_trig+1).
- R10: In transmit transparent mode, tx_irq is 1 for one cycle after each write that is stored and leaves tx_level below capacity; takes alone do not set it.
- R11: On a full enabled queue, a store and a removal in the same cycle are both accepted: the level stays at DEPTH, no overrun is flagged, and the new byte is delivered after those already held.
- R12: With the enable clear, the trigger code is ignored and the threshold is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive queue enable (0 = single-byte buffer) |
| rx_flush | input | 1 | Receive flush strobe |
| rx_trig | input | PW (3) | Receive threshold code; the level is code+1 |
| rx_transparent | input | 1 | Receive transparent mode |
| rx_in_valid | input | 1 | Deserializer byte strobe |
| rx_in_data | input | DW (8) | Deserializer byte |
| rx_rd | input | 1 | CPU read strobe; removes the oldest byte |
| rx_rd_data | output | DW (8) | Oldest received byte (show-ahead) |
| rx_level | output | LW (4) | Receive bytes held |
| rx_irq | output | 1 | Receive interrupt request |
| rx_overrun | output | 1 | Pulse: a received byte was discarded |
| tx_en | input | 1 | Transmit queue enable (0 = single-byte buffer) |
| tx_flush | input | 1 | Transmit flush strobe |
| tx_trig | input | PW (3) | Transmit threshold code; the level is code+1 |
| tx_transparent | input | 1 | Transmit transparent mode |
| tx_wr | input | 1 | CPU write strobe |
| tx_wr_data | input | DW (8) | CPU write byte |
| tx_take | input | 1 | Serializer take strobe; removes the oldest byte |
| tx_out_valid | output | 1 | A transmit byte is available |
| tx_out_data | output | DW (8) | Oldest queued transmit byte (show-ahead) |
| tx_level | output | LW (4) | Transmit bytes queued |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The key coincidence is a store and a removal landing on the same edge while the queue is full. The overrun logic and the level counter then disagree about whether there is room.

The bench provokes this on each side:
- It fills the receive queue, then pulses rx_in_valid and rx_rd together.
- It fills the transmit queue, then pulses tx_wr and tx_take together.

Each case is judged in three ways:
- the level must stay at 8;
- rx_overrun must stay low;
- the drained sequence must end with the new byte.

A second coincidence is a flush on the same edge as a store. The bench judges this by a zero level and by the stale and offered bytes never reappearing.

// File: rtl/sioq_pkg.sv
package sioq_pkg;

  // Threshold selected by a trigger code: code+1 when the queue is enabled,
  // otherwise a fixed threshold of one byte.
  function automatic int unsigned eff_thr(input logic en, input int unsigned code);
    return en ? (code + 1) : 1;
  endfunction

  // Free slots for a given capacity and fill, never negative.
  function automatic int unsigned free_of(input int unsigned cap, input int unsigned lvl);
    return (lvl >= cap) ? 0 : (cap - lvl);
  endfunction

endpackage

// File: rtl/sioq_fifo.sv
module sioq_fifo #(
  parameter  int DEPTH = 8,
  parameter  int DW    = 8,
  localparam int PW    = $clog2(DEPTH),
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [LW-1:0] level,
  output logic [LW-1:0] level_nxt,
  output logic [LW-1:0] cap,
  output logic          push_ok,
  output logic          push_drop
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, wr_ptr_nxt;
  logic [PW-1:0] rd_ptr, rd_ptr_nxt;
  logic          pop_ok;
  logic          room;

  // next-state logic
  always_comb begin
    cap       = en ? LW'(DEPTH) : LW'(1);
    pop_ok    = pop && (level != '0) && !flush;
    room      = (level < cap) || (pop_ok && (level <= cap));
    push_ok   = push && !flush && room;
    push_drop = push && !flush && !room;

    if (flush) begin
      level_nxt  = '0;
      wr_ptr_nxt = '0;
      rd_ptr_nxt = '0;
    end else begin
      level_nxt  = level + LW'(push_ok) - LW'(pop_ok);
      wr_ptr_nxt = wr_ptr;
      rd_ptr_nxt = rd_ptr;
      if (push_ok) wr_ptr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      level  <= level_nxt;
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
    end
  end

  // storage, written only under its clock enable
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  assign pop_data = mem[rd_ptr];

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0)); // R4
  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en) && $past(level <= 1)) |-> (level <= 1)); // R3
  AST_DROP_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> (level <= $past(level))); // R5

endmodule

// File: rtl/sioq_trig.sv
module sioq_trig #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          transparent,
  input  logic [LW-1:0] cur,
  input  logic [LW-1:0] nxt,
  input  logic [LW-1:0] thr,
  input  logic          evt,
  output logic          irq
);

  logic irq_nxt;

  // Normal mode: one pulse when the watched count crosses up to the threshold.
  // Transparent mode: follows the caller's per-cycle event.
  always_comb begin
    if (transparent) irq_nxt = evt;
    else             irq_nxt = (cur < thr) && (nxt >= thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_nxt;
  end

  AST_NORMAL_NEEDS_REACH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(transparent)) |-> ($past(nxt) >= $past(thr))); // R7

endmodule

// File: rtl/sio_fifo_pair.sv
module sio_fifo_pair
  import sioq_pkg::*;
#(
  parameter  int DEPTH = 8,
  parameter  int DW    = 8,
  localparam int PW    = $clog2(DEPTH),
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          rx_flush,
  input  logic [PW-1:0] rx_trig,
  input  logic          rx_transparent,
  input  logic          rx_in_valid,
  input  logic [DW-1:0] rx_in_data,
  input  logic          rx_rd,
  output logic [DW-1:0] rx_rd_data,
  output logic [LW-1:0] rx_level,
  output logic          rx_irq,
  output logic          rx_overrun,
  input  logic          tx_en,
  input  logic          tx_flush,
  input  logic [PW-1:0] tx_trig,
  input  logic          tx_transparent,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_wr_data,
  input  logic          tx_take,
  output logic          tx_out_valid,
  output logic [DW-1:0] tx_out_data,
  output logic [LW-1:0] tx_level,
  output logic          tx_irq
);

  logic [LW-1:0] rx_lnxt, rx_cap, rx_thr;
  logic          rx_push_ok, rx_drop;
  logic [LW-1:0] tx_lnxt, tx_cap, tx_thr, tx_free, tx_free_nxt;
  logic          tx_push_ok, tx_drop;
  logic          tx_evt;

  // ---------------- receive direction ----------------
  sioq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .flush(rx_flush),
    .push(rx_in_valid), .push_data(rx_in_data), .pop(rx_rd),
    .pop_data(rx_rd_data), .level(rx_level), .level_nxt(rx_lnxt),
    .cap(rx_cap), .push_ok(rx_push_ok), .push_drop(rx_drop)
  );

  assign rx_thr = LW'(eff_thr(rx_en, int'(rx_trig)));

  sioq_trig #(.LW(LW)) u_rxirq (
    .clk(clk), .rst_n(rst_n), .transparent(rx_transparent),
    .cur(rx_level), .nxt(rx_lnxt), .thr(rx_thr),
    .evt(rx_lnxt != '0), .irq(rx_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_overrun <= 1'b0;
    else        rx_overrun <= rx_drop;
  end

  // ---------------- transmit direction ----------------
  sioq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .flush(tx_flush),
    .push(tx_wr), .push_data(tx_wr_data), .pop(tx_take),
    .pop_data(tx_out_data), .level(tx_level), .level_nxt(tx_lnxt),
    .cap(tx_cap), .push_ok(tx_push_ok), .push_drop(tx_drop)
  );

  always_comb begin
    tx_thr      = LW'(eff_thr(tx_en, int'(tx_trig)));
    tx_free     = LW'(free_of(int'(tx_cap), int'(tx_level)));
    tx_free_nxt = LW'(free_of(int'(tx_cap), int'(tx_lnxt)));
    tx_evt      = tx_push_ok && (tx_lnxt < tx_cap);
  end

  sioq_trig #(.LW(LW)) u_txirq (
    .clk(clk), .rst_n(rst_n), .transparent(tx_transparent),
    .cur(tx_free), .nxt(tx_free_nxt), .thr(tx_thr),
    .evt(tx_evt), .irq(tx_irq)
  );

  assign tx_out_valid = (tx_level != '0);

  AST_RX_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_transparent) |-> (rx_irq == (rx_level != '0))); // R8
  AST_RX_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> $past(rx_in_valid)); // R5
  AST_RX_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push_ok && !rx_rd) |=> (rx_level == $past(rx_level) + 1'b1)); // R2
  AST_TX_FULL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> (tx_level <= $past(tx_level))); // R6
  AST_TX_TRANSP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && $past(tx_transparent)) |-> $past(tx_wr)); // R10

endmodule

// File: tb/sim_sio_fifo_pair.sv
module sim_sio_fifo_pair;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_en, rx_flush, rx_transparent, rx_in_valid, rx_rd;
  logic [2:0] rx_trig;
  logic [7:0] rx_in_data, rx_rd_data;
  logic [3:0] rx_level;
  logic rx_irq, rx_overrun;
  logic tx_en, tx_flush, tx_transparent, tx_wr, tx_take, tx_out_valid, tx_irq;
  logic [2:0] tx_trig;
  logic [7:0] tx_wr_data, tx_out_data;
  logic [3:0] tx_level;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sio_fifo_pair u0 (
    .clk(clk), .rst_n(rst_n),
    .rx_en(rx_en), .rx_flush(rx_flush), .rx_trig(rx_trig), .rx_transparent(rx_transparent),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_rd(rx_rd),
    .rx_rd_data(rx_rd_data), .rx_level(rx_level), .rx_irq(rx_irq), .rx_overrun(rx_overrun),
    .tx_en(tx_en), .tx_flush(tx_flush), .tx_trig(tx_trig), .tx_transparent(tx_transparent),
    .tx_wr(tx_wr), .tx_wr_data(tx_wr_data), .tx_take(tx_take),
    .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data), .tx_level(tx_level), .tx_irq(tx_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rx_push(input logic [7:0] d);
    rx_in_valid = 1'b1; rx_in_data = d; tick(); rx_in_valid = 1'b0;
  endtask

  task automatic rx_read(input string req, input logic [7:0] exp);
    chk(req, int'(rx_rd_data), int'(exp));
    rx_rd = 1'b1; tick(); rx_rd = 1'b0;
  endtask

  task automatic tx_write(input logic [7:0] d);
    tx_wr = 1'b1; tx_wr_data = d; tick(); tx_wr = 1'b0;
  endtask

  task automatic tx_pull(input string req, input logic [7:0] exp);
    chk(req, int'(tx_out_data), int'(exp));
    tx_take = 1'b1; tick(); tx_take = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    rx_en = 1'b1; rx_flush = 0; rx_trig = 0; rx_transparent = 0;
    rx_in_valid = 0; rx_in_data = 0; rx_rd = 0;
    tx_en = 1'b1; tx_flush = 0; tx_trig = 0; tx_transparent = 0;
    tx_wr = 0; tx_wr_data = 0; tx_take = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 rx_level", int'(rx_level), 0);
    chk("R1 tx_level", int'(tx_level), 0);
    chk("R1 rx_irq", int'(rx_irq), 0);
    chk("R1 tx_irq", int'(tx_irq), 0);
    chk("R1 rx_overrun", int'(rx_overrun), 0);
    chk("R1 tx_out_valid", int'(tx_out_valid), 0);

    // R7 / R2 / R5: receive threshold sweep over every code
    for (int t = 0; t < DEPTH; t++) begin
      rx_trig = 3'(t);
      rx_flush = 1'b1; tick(); rx_flush = 1'b0;
      for (int k = 1; k <= DEPTH; k++) begin
        rx_push(8'(t * 16 + k));
        chk("R2 rx level", int'(rx_level), k);
        chk("R7 rx irq", int'(rx_irq), (k == t + 1) ? 1 : 0);
      end
      rx_push(8'hFF);
      chk("R5 overrun flag", int'(rx_overrun), 1);
      chk("R5 level kept", int'(rx_level), DEPTH);
      tick();
      chk("R5 overrun one cycle", int'(rx_overrun), 0);
      for (int k = 1; k <= DEPTH; k++) begin
        rx_read("R2 rx order", 8'(t * 16 + k));
        chk("R7 no irq on read", int'(rx_irq), 0);
        chk("R2 rx level drain", int'(rx_level), DEPTH - k);
      end
    end

    // R4: flush with a byte offered in the same cycle
    rx_trig = 3'd7;
    rx_push(8'hA1); rx_push(8'hA2);
    rx_flush = 1'b1; rx_in_valid = 1'b1; rx_in_data = 8'hA3; tick();
    rx_flush = 1'b0; rx_in_valid = 1'b0;
    chk("R4 rx flushed level", int'(rx_level), 0);
    rx_push(8'hA4);
    chk("R4 level after flush", int'(rx_level), 1);
    rx_read("R4 stale bytes gone", 8'hA4);

    // R11: full receive queue, store and read together
    for (int k = 1; k <= DEPTH; k++) rx_push(8'(8'hC0 + k));
    chk("R11 rx oldest shown", int'(rx_rd_data), 8'hC1);
    rx_in_valid = 1'b1; rx_in_data = 8'hEE; rx_rd = 1'b1; tick();
    rx_in_valid = 1'b0; rx_rd = 1'b0;
    chk("R11 rx level held", int'(rx_level), DEPTH);
    chk("R11 rx no overrun", int'(rx_overrun), 0);
    for (int k = 2; k <= DEPTH; k++) rx_read("R11 rx order", 8'(8'hC0 + k));
    rx_read("R11 rx new last", 8'hEE);

    // R3 / R12: receive queue disabled
    rx_en = 1'b0; rx_trig = 3'd5; tick();
    rx_push(8'h11);
    chk("R3 rx single level", int'(rx_level), 1);
    chk("R12 rx thr one", int'(rx_irq), 1);
    rx_push(8'h22);
    chk("R3 rx second refused", int'(rx_overrun), 1);
    chk("R3 rx level one", int'(rx_level), 1);
    rx_read("R3 rx kept first", 8'h11);
    rx_en = 1'b1; tick();

    // R8: receive transparent mode
    rx_transparent = 1'b1; tick();
    chk("R8 idle no irq", int'(rx_irq), 0);
    for (int k = 1; k <= 3; k++) begin
      rx_push(8'(8'h30 + k));
      chk("R8 irq with data", int'(rx_irq), 1);
    end
    for (int k = 1; k <= 3; k++) begin
      rx_read("R8 order", 8'(8'h30 + k));
      chk("R8 irq follows level", int'(rx_irq), (k < 3) ? 1 : 0);
    end
    rx_transparent = 1'b0; tick();

    // R9 / R6 / R2: transmit threshold sweep over every code
    for (int t = 0; t < DEPTH; t++) begin
      tx_trig = 3'(t);
      for (int k = 1; k <= DEPTH; k++) begin
        tx_write(8'(t * 16 + k));
        chk("R2 tx level", int'(tx_level), k);
        chk("R9 no irq on write", int'(tx_irq), 0);
      end
      tx_write(8'hFF);
      chk("R6 tx full level", int'(tx_level), DEPTH);
      chk("R6 tx head unchanged", int'(tx_out_data), t * 16 + 1);
      for (int j = 1; j <= DEPTH; j++) begin
        tx_pull("R2 tx order", 8'(t * 16 + j));
        chk("R9 tx irq", int'(tx_irq), (j == t + 1) ? 1 : 0);
      end
      chk("R2 tx empty", int'(tx_out_valid), 0);
    end

    // R10: transmit transparent mode
    tx_transparent = 1'b1; tick();
    for (int k = 1; k <= DEPTH; k++) begin
      tx_write(8'(8'h50 + k));
      chk("R10 irq per write", int'(tx_irq), (k < DEPTH) ? 1 : 0);
    end
    for (int k = 1; k <= DEPTH; k++) begin
      tx_pull("R10 order", 8'(8'h50 + k));
      chk("R10 no irq on take", int'(tx_irq), 0);
    end
    tx_transparent = 1'b0;

    // R3 / R12: transmit queue disabled
    tx_en = 1'b0; tx_trig = 3'd6; tick();
    tx_write(8'h61);
    chk("R3 tx single level", int'(tx_level), 1);
    tx_write(8'h62);
    chk("R3 tx second ignored", int'(tx_level), 1);
    tx_pull("R3 tx kept first", 8'h61);
    chk("R12 tx thr one", int'(tx_irq), 1);
    tx_en = 1'b1; tick();

    // R11: full transmit queue, write and take together
    tx_trig = 3'd0;
    for (int k = 1; k <= DEPTH; k++) tx_write(8'(8'h70 + k));
    chk("R11 tx oldest shown", int'(tx_out_data), 8'h71);
    tx_wr = 1'b1; tx_wr_data = 8'h5A; tx_take = 1'b1; tick();
    tx_wr = 1'b0; tx_take = 1'b0;
    chk("R11 tx level held", int'(tx_level), DEPTH);
    for (int k = 2; k <= DEPTH; k++) tx_pull("R11 tx order", 8'(8'h70 + k));
    tx_pull("R11 tx new last", 8'h5A);

    // R4 on transmit side
    tx_write(8'h81); tx_write(8'h82);
    tx_flush = 1'b1; tx_wr = 1'b1; tx_wr_data = 8'h83; tick();
    tx_flush = 1'b0; tx_wr = 1'b0;
    chk("R4 tx flushed", int'(tx_level), 0);
    chk("R4 tx no valid", int'(tx_out_valid), 0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule